// File: doc/BRIEF.md
# Shared-Storage Dual-Port RAM with Collision Flags and Mailbox Interrupts

This block is a synchronous memory with two identical access ports, called left and right, that share one clock and one storage array. Each port has its own address, write data, read data, lane selects, read/write select, a pair of chip enables and an output enable. Either port can read or write any location in any cycle. Reads are registered, so the data appears one clock after the read is taken.

The block adds two services on top of the shared storage. The first is a delayed busy flag. When both ports are enabled and present the same address in the same cycle, both busy outputs pulse high for one cycle, four clocks after that access is sampled. The second uses the two highest locations as one-deep message slots between the ports. When one port writes the slot that belongs to the other port, the owner's active-low interrupt is asserted. The interrupt is released when the owner reads its own slot.

The port pins are plain control and data pins, not a valid/ready stream. The block never stalls and has no back-pressure. Every enabled access is taken on the edge where it is presented.

Top module: `dpmb_ram`

## Requirements
- R1: A port is enabled only when its chip-enable-low input is 0 and its chip-enable-high input is 1. A port that is not enabled writes nothing, and its read register keeps its value.
- R2: An enabled port with read/write select 0 writes a lane only where that lane's select bit is 1. Lane i is data bits [9i+8:9i]. Other lanes of the location keep their contents.
- R3: An enabled port with read/write select 1 loads its read register on the clock edge. Selected lanes take the stored contents and unselected lanes take zero. The read register holds that value until the port's next enabled read.
- R4: If both ports write the same lane of the same address in one cycle, the left port's data is stored. Writes to different addresses in one cycle both take effect.
- R5: The read data bus shows the read register while output enable (active low) is 0. While it is 1, the bus is released to high impedance at once; in the bench the bus is pulled up, so it reads all ones.
- R6: If both ports are enabled with equal addresses at a sampling edge, both busy outputs are 1 in the cycle that follows the fourth edge after that one. Each colliding cycle gives exactly one busy cycle. No busy pulse occurs otherwise.
- R7: Address 2^AW-1 is the left slot and address 2^AW-2 is the right slot. A write by the right port to the left slot drives the left interrupt low after the edge, and a write by the left port to the right slot does the same for the right interrupt.
- R8: A port's interrupt returns high after the edge on which that port reads its own slot.
- R9: A port writing its own slot, or reading the other port's slot, leaves both interrupts unchanged. When a set and a release of the same interrupt fall in one cycle, the set wins.
- R10: After reset, both interrupts are high, both busy outputs are low and both read registers are zero.
- R11: If a port reads an address in the same cycle that the other port writes it, the read returns the contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for both ports |
| rst_n | input | 1 | Asynchronous active-low reset |
| lt_addr | input | AW | Left address |
| lt_wdata | input | LANES*LANE_W | Left write data |
| lt_rdata | output | LANES*LANE_W | Left read data, high impedance while output enable is off |
| lt_bsel | input | LANES | Left lane selects |
| lt_rnw | input | 1 | Left read (1) or write (0) |
| lt_ce_n | input | 1 | Left chip enable, active low |
| lt_ce | input | 1 | Left chip enable, active high |
| lt_oe_n | input | 1 | Left output enable, active low, combinational |
| lt_busy | output | 1 | Left collision flag, delayed |
| lt_irq_n | output | 1 | Left mailbox interrupt, active low |
| rt_addr | input | AW | Right address |
| rt_wdata | input | LANES*LANE_W | Right write data |
| rt_rdata | output | LANES*LANE_W | Right read data, high impedance while output enable is off |
| rt_bsel | input | LANES | Right lane selects |
| rt_rnw | input | 1 | Right read (1) or write (0) |
| rt_ce_n | input | 1 | Right chip enable, active low |
| rt_ce | input | 1 | Right chip enable, active high |
| rt_oe_n | input | 1 | Right output enable, active low, combinational |
| rt_busy | output | 1 | Right collision flag, delayed |
| rt_irq_n | output | 1 | Right mailbox interrupt, active low |

## Verification
Read data and both interrupts are due one cycle after the edge that samples the access. Busy is due four cycles after that, one per colliding sampling edge. The output-enable effect is immediate, within the cycle in which it is driven.

For every cycle it drives, the bench computes the expected read buses, interrupts and busy flags and files each one under the cycle in which it is due. The monitor compares, at the falling clock edge, only the items whose due cycle has come. Because inputs change just after that falling edge, the combinational output-enable path is judged against the access whose result is being checked.

// File: rtl/dpmb_pkg.sv
package dpmb_pkg;
  localparam int unsigned DEF_AW     = 10;
  localparam int unsigned DEF_LANES  = 8;
  localparam int unsigned DEF_LANE_W = 9;
  localparam int unsigned BUSY_LAT   = 5;
  localparam int unsigned NPORT      = 2;

  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_e;
endpackage

// File: rtl/dpmb_port_dec.sv
module dpmb_port_dec
  import dpmb_pkg::*;
(
  input  logic ce_n,
  input  logic ce,
  input  logic rnw,
  output acc_e kind
);
  logic sel;

  assign sel = ~ce_n & ce;

  always_comb begin
    kind = ACC_IDLE;
    if (sel) kind = rnw ? ACC_READ : ACC_WRITE;
  end
endmodule

// File: rtl/dpmb_array.sv
module dpmb_array
  import dpmb_pkg::*;
#(
  parameter int unsigned AW     = DEF_AW,
  parameter int unsigned LANES  = DEF_LANES,
  parameter int unsigned LANE_W = DEF_LANE_W
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [NPORT-1:0]                     wr,
  input  logic [NPORT-1:0]                     rd,
  input  logic [NPORT-1:0][AW-1:0]             addr,
  input  logic [NPORT-1:0][LANES-1:0]          bsel,
  input  logic [NPORT-1:0][LANES*LANE_W-1:0]   wdata,
  output logic [NPORT-1:0][LANES*LANE_W-1:0]   rq
);
  localparam int unsigned DEPTH = 1 << AW;
  localparam int unsigned DW    = LANES * LANE_W;

  logic [DW-1:0] store [DEPTH];

  // Right lanes are written first so a left write to the same lane overrides.
  always_ff @(posedge clk) begin
    for (int ln = 0; ln < LANES; ln++) begin
      if (wr[1] && bsel[1][ln])
        store[addr[1]][ln*LANE_W +: LANE_W] <= wdata[1][ln*LANE_W +: LANE_W];
      if (wr[0] && bsel[0][ln])
        store[addr[0]][ln*LANE_W +: LANE_W] <= wdata[0][ln*LANE_W +: LANE_W];
    end
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_rd
    logic [DW-1:0] q;
    logic [DW-1:0] word;

    assign word = store[addr[p]];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (rd[p]) begin
        for (int ln = 0; ln < LANES; ln++)
          q[ln*LANE_W +: LANE_W] <= bsel[p][ln] ? word[ln*LANE_W +: LANE_W] : '0;
      end
    end

    assign rq[p] = q;
  end
endmodule

// File: rtl/dpmb_busy.sv
module dpmb_busy
  import dpmb_pkg::*;
#(
  parameter int unsigned AW  = DEF_AW,
  parameter int unsigned LAT = BUSY_LAT
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NPORT-1:0]         en,
  input  logic [NPORT-1:0][AW-1:0] addr,
  output logic [NPORT-1:0]         busy
);
  logic hit;

  assign hit = (&en) && (addr[0] == addr[1]);

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic [LAT-1:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= '0;
      else        pipe <= {pipe[LAT-2:0], hit};
    end

    assign busy[p] = pipe[LAT-1];
  end
endmodule

// File: rtl/dpmb_mailbox.sv
module dpmb_mailbox
  import dpmb_pkg::*;
#(
  parameter int unsigned AW = DEF_AW
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NPORT-1:0]         wr,
  input  logic [NPORT-1:0]         rd,
  input  logic [NPORT-1:0][AW-1:0] addr,
  output logic [NPORT-1:0]         irq_n
);
  localparam logic [AW-1:0] SLOT_L = {AW{1'b1}};
  localparam logic [AW-1:0] SLOT_R = {{(AW-1){1'b1}}, 1'b0};

  for (genvar p = 0; p < NPORT; p++) begin : g_slot
    localparam logic [AW-1:0] OWN  = (p == 0) ? SLOT_L : SLOT_R;
    localparam int unsigned   PEER = NPORT - 1 - p;
    logic post, take, flag_n;

    assign post = wr[PEER] && (addr[PEER] == OWN);
    assign take = rd[p] && (addr[p] == OWN);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    flag_n <= 1'b1;
      else if (post) flag_n <= 1'b0;
      else if (take) flag_n <= 1'b1;
    end

    assign irq_n[p] = flag_n;
  end
endmodule

// File: rtl/dpmb_ram.sv
module dpmb_ram
  import dpmb_pkg::*;
#(
  parameter int unsigned AW     = DEF_AW,
  parameter int unsigned LANES  = DEF_LANES,
  parameter int unsigned LANE_W = DEF_LANE_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [AW-1:0]           lt_addr,
  input  logic [LANES*LANE_W-1:0] lt_wdata,
  output logic [LANES*LANE_W-1:0] lt_rdata,
  input  logic [LANES-1:0]        lt_bsel,
  input  logic                    lt_rnw,
  input  logic                    lt_ce_n,
  input  logic                    lt_ce,
  input  logic                    lt_oe_n,
  output logic                    lt_busy,
  output logic                    lt_irq_n,
  input  logic [AW-1:0]           rt_addr,
  input  logic [LANES*LANE_W-1:0] rt_wdata,
  output logic [LANES*LANE_W-1:0] rt_rdata,
  input  logic [LANES-1:0]        rt_bsel,
  input  logic                    rt_rnw,
  input  logic                    rt_ce_n,
  input  logic                    rt_ce,
  input  logic                    rt_oe_n,
  output logic                    rt_busy,
  output logic                    rt_irq_n
);
  localparam int unsigned DW = LANES * LANE_W;

  logic [NPORT-1:0]           ce_n_v, ce_v, rnw_v;
  logic [NPORT-1:0][AW-1:0]   addr_v;
  logic [NPORT-1:0][LANES-1:0] bsel_v;
  logic [NPORT-1:0][DW-1:0]   wdata_v;
  logic [NPORT-1:0][DW-1:0]   rq;
  logic [NPORT-1:0]           en, wr, rd, busy, irq_n;

  assign ce_n_v  = {rt_ce_n, lt_ce_n};
  assign ce_v    = {rt_ce, lt_ce};
  assign rnw_v   = {rt_rnw, lt_rnw};
  assign addr_v  = {rt_addr, lt_addr};
  assign bsel_v  = {rt_bsel, lt_bsel};
  assign wdata_v = {rt_wdata, lt_wdata};

  for (genvar p = 0; p < NPORT; p++) begin : g_dec
    acc_e kind;

    dpmb_port_dec u_dec (
      .ce_n (ce_n_v[p]),
      .ce   (ce_v[p]),
      .rnw  (rnw_v[p]),
      .kind (kind)
    );

    assign wr[p] = (kind == ACC_WRITE);
    assign rd[p] = (kind == ACC_READ);
    assign en[p] = (kind != ACC_IDLE);
  end

  dpmb_array #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (wr),
    .rd    (rd),
    .addr  (addr_v),
    .bsel  (bsel_v),
    .wdata (wdata_v),
    .rq    (rq)
  );

  dpmb_busy #(.AW(AW), .LAT(BUSY_LAT)) u_busy (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .addr  (addr_v),
    .busy  (busy)
  );

  dpmb_mailbox #(.AW(AW)) u_mbox (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (wr),
    .rd    (rd),
    .addr  (addr_v),
    .irq_n (irq_n)
  );

  assign lt_rdata = lt_oe_n ? {DW{1'bz}} : rq[0];
  assign rt_rdata = rt_oe_n ? {DW{1'bz}} : rq[1];
  assign lt_busy  = busy[0];
  assign rt_busy  = busy[1];
  assign lt_irq_n = irq_n[0];
  assign rt_irq_n = irq_n[1];
endmodule

// File: rtl/dpmb_ram_chk.sv
module dpmb_ram_chk
  import dpmb_pkg::*;
#(
  parameter int unsigned AW     = DEF_AW,
  parameter int unsigned LANES  = DEF_LANES,
  parameter int unsigned LANE_W = DEF_LANE_W
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic [AW-1:0]                    lt_addr,
  input logic                             lt_rnw,
  input logic                             lt_ce_n,
  input logic                             lt_ce,
  input logic                             lt_oe_n,
  input logic [LANES*LANE_W-1:0]          lt_rdata,
  input logic                             lt_busy,
  input logic                             lt_irq_n,
  input logic [AW-1:0]                    rt_addr,
  input logic                             rt_rnw,
  input logic                             rt_ce_n,
  input logic                             rt_ce,
  input logic                             rt_busy,
  input logic                             rt_irq_n,
  input logic [NPORT-1:0][LANES*LANE_W-1:0] rq
);
  localparam logic [AW-1:0] SLOT_L = {AW{1'b1}};
  localparam logic [AW-1:0] SLOT_R = {{(AW-1){1'b1}}, 1'b0};

  logic l_on, r_on, same, l_post, r_post, l_take;
  logic [2:0] since;

  assign l_on   = !lt_ce_n && lt_ce;
  assign r_on   = !rt_ce_n && rt_ce;
  assign same   = l_on && r_on && (lt_addr == rt_addr);
  assign l_post = r_on && !rt_rnw && (rt_addr == SLOT_L);
  assign r_post = l_on && !lt_rnw && (lt_addr == SLOT_R);
  assign l_take = l_on && lt_rnw && (lt_addr == SLOT_L);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            since <= '0;
    else if (since != 3'd7) since <= since + 3'd1;
  end

  assert_busy_delay_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (since >= 3'd5) |-> (lt_busy == $past(same, 5)));

  assert_busy_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lt_busy == rt_busy);

  assert_left_post_R7: assert property (@(posedge clk) disable iff (!rst_n)
    l_post |=> !lt_irq_n);

  assert_right_post_R7: assert property (@(posedge clk) disable iff (!rst_n)
    r_post |=> !rt_irq_n);

  assert_left_take_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (l_take && !l_post) |=> lt_irq_n);

  assert_left_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_post && !l_take) |=> $stable(lt_irq_n));

  assert_rd_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(l_on && lt_rnw) |=> $stable(rq[0]));

  assert_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !lt_oe_n |-> (lt_rdata == rq[0]));
endmodule

bind dpmb_ram dpmb_ram_chk #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .lt_addr  (lt_addr),
  .lt_rnw   (lt_rnw),
  .lt_ce_n  (lt_ce_n),
  .lt_ce    (lt_ce),
  .lt_oe_n  (lt_oe_n),
  .lt_rdata (lt_rdata),
  .lt_busy  (lt_busy),
  .lt_irq_n (lt_irq_n),
  .rt_addr  (rt_addr),
  .rt_rnw   (rt_rnw),
  .rt_ce_n  (rt_ce_n),
  .rt_ce    (rt_ce),
  .rt_busy  (rt_busy),
  .rt_irq_n (rt_irq_n),
  .rq       (rq)
);

// File: tb/dpmb_ram_tb.sv
`timescale 1ns/1ps
module dpmb_ram_tb;
  localparam int AW = 10, LANES = 8, LW = 9, DW = LANES * LW;
  localparam int DEPTH = 1 << AW, MB_L = DEPTH - 1, MB_R = DEPTH - 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [AW-1:0] lt_addr, rt_addr;
  logic [DW-1:0] lt_wdata, rt_wdata;
  tri1  [DW-1:0] lt_rdata;
  tri1  [DW-1:0] rt_rdata;
  logic [LANES-1:0] lt_bsel, rt_bsel;
  logic lt_rnw, lt_ce_n, lt_ce, lt_oe_n, rt_rnw, rt_ce_n, rt_ce, rt_oe_n;
  logic lt_busy, lt_irq_n, rt_busy, rt_irq_n;

  dpmb_ram u_dut (
    .clk(clk), .rst_n(rst_n),
    .lt_addr(lt_addr), .lt_wdata(lt_wdata), .lt_rdata(lt_rdata), .lt_bsel(lt_bsel),
    .lt_rnw(lt_rnw), .lt_ce_n(lt_ce_n), .lt_ce(lt_ce), .lt_oe_n(lt_oe_n),
    .lt_busy(lt_busy), .lt_irq_n(lt_irq_n),
    .rt_addr(rt_addr), .rt_wdata(rt_wdata), .rt_rdata(rt_rdata), .rt_bsel(rt_bsel),
    .rt_rnw(rt_rnw), .rt_ce_n(rt_ce_n), .rt_ce(rt_ce), .rt_oe_n(rt_oe_n),
    .rt_busy(rt_busy), .rt_irq_n(rt_irq_n)
  );

  // ce code: 0 enabled, 1 chip-enable-low held high, 2 chip-enable-high held low
  typedef struct {int ce; bit rnw; int addr; logic [LANES-1:0] be; logic [DW-1:0] data; bit oe_n;} op_t;
  typedef struct {int due; int kind; logic [DW-1:0] exp; string tag;} item_t;

  item_t sb[$];
  int cyc = 0, n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [DW-1:0] mmem [DEPTH];
  logic [DW-1:0] m_lq = '0, m_rq = '0;
  logic m_lirq = 1'b1, m_rirq = 1'b1;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic op_t mk(int ce, bit rnw, int addr, logic [LANES-1:0] be,
                             logic [DW-1:0] data = '0, bit oe_n = 1'b0);
    op_t o;
    o.ce = ce; o.rnw = rnw; o.addr = addr; o.be = be; o.data = data; o.oe_n = oe_n;
    return o;
  endfunction

  function automatic logic [DW-1:0] lmask(logic [LANES-1:0] be);
    logic [DW-1:0] m;
    for (int i = 0; i < LANES; i++) m[i*LW +: LW] = be[i] ? {LW{1'b1}} : {LW{1'b0}};
    return m;
  endfunction

  function automatic logic [DW-1:0] rdat();
    return {$urandom, $urandom, $urandom};
  endfunction

  task automatic check(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s cycle %0d actual=%h expected=%h", tag, what, cyc, act, exp);
    end
  endtask

  function automatic void push(int due, int kind, logic [DW-1:0] exp, string tag);
    item_t it;
    it.due = due; it.kind = kind; it.exp = exp; it.tag = tag;
    sb.push_back(it);
  endfunction

  // Monitor: compares every item whose due cycle has arrived.
  always @(negedge clk) begin
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].due == cyc) begin
        case (sb[i].kind)
          0: check(sb[i].tag, "lt_rdata", lt_rdata, sb[i].exp);
          1: check(sb[i].tag, "rt_rdata", rt_rdata, sb[i].exp);
          2: check(sb[i].tag, "lt_busy", {{(DW-1){1'b0}}, lt_busy}, sb[i].exp);
          3: check(sb[i].tag, "rt_busy", {{(DW-1){1'b0}}, rt_busy}, sb[i].exp);
          4: check(sb[i].tag, "lt_irq_n", {{(DW-1){1'b0}}, lt_irq_n}, sb[i].exp);
          default: check(sb[i].tag, "rt_irq_n", {{(DW-1){1'b0}}, rt_irq_n}, sb[i].exp);
        endcase
        sb.delete(i);
      end
    end
  end

  // Driver: applies one cycle on both ports and files the expected results.
  task automatic drive(op_t l, op_t r, string tag);
    bit le, re, coll, lset, lclr, rset, rclr;
    @(negedge clk); #1;
    lt_ce_n = (l.ce == 1); lt_ce = (l.ce != 2); lt_rnw = l.rnw; lt_addr = AW'(l.addr);
    lt_bsel = l.be; lt_wdata = l.data; lt_oe_n = l.oe_n;
    rt_ce_n = (r.ce == 1); rt_ce = (r.ce != 2); rt_rnw = r.rnw; rt_addr = AW'(r.addr);
    rt_bsel = r.be; rt_wdata = r.data; rt_oe_n = r.oe_n;
    le = (l.ce == 0); re = (r.ce == 0);
    coll = le && re && (l.addr == r.addr);
    if (le && l.rnw) m_lq = mmem[l.addr] & lmask(l.be);
    if (re && r.rnw) m_rq = mmem[r.addr] & lmask(r.be);
    lset = re && !r.rnw && (r.addr == MB_L);
    lclr = le && l.rnw && (l.addr == MB_L);
    rset = le && !l.rnw && (l.addr == MB_R);
    rclr = re && r.rnw && (r.addr == MB_R);
    if (lset) m_lirq = 1'b0; else if (lclr) m_lirq = 1'b1;
    if (rset) m_rirq = 1'b0; else if (rclr) m_rirq = 1'b1;
    if (re && !r.rnw) mmem[r.addr] = (mmem[r.addr] & ~lmask(r.be)) | (r.data & lmask(r.be));
    if (le && !l.rnw) mmem[l.addr] = (mmem[l.addr] & ~lmask(l.be)) | (l.data & lmask(l.be));
    push(cyc + 1, 0, l.oe_n ? {DW{1'b1}} : m_lq, tag);
    push(cyc + 1, 1, r.oe_n ? {DW{1'b1}} : m_rq, tag);
    push(cyc + 1, 4, DW'(m_lirq), tag);
    push(cyc + 1, 5, DW'(m_rirq), tag);
    push(cyc + 5, 2, DW'(coll), "R6");
    push(cyc + 5, 3, DW'(coll), "R6");
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired, all requirements unfinished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    op_t idle;
    logic [DW-1:0] d1, d2, d3;
    int pick [6] = '{0, 1, 2, 3, MB_L, MB_R};
    idle = mk(1, 1, 0, '0);
    lt_ce_n = 1; lt_ce = 1; lt_rnw = 1; lt_addr = '0; lt_bsel = '0; lt_wdata = '0; lt_oe_n = 0;
    rt_ce_n = 1; rt_ce = 1; rt_rnw = 1; rt_addr = '0; rt_bsel = '0; rt_wdata = '0; rt_oe_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    check("R10", "lt_irq_n", DW'(lt_irq_n), DW'(1));
    check("R10", "rt_irq_n", DW'(rt_irq_n), DW'(1));
    check("R10", "lt_busy", DW'(lt_busy), '0);
    check("R10", "rt_busy", DW'(rt_busy), '0);
    check("R10", "lt_rdata", lt_rdata, '0);
    check("R10", "rt_rdata", rt_rdata, '0);

    d1 = rdat(); d2 = rdat(); d3 = rdat();
    drive(mk(0, 0, 5, '1, d1), mk(0, 0, 7, '1, d2), "R2");
    drive(mk(0, 1, 7, '1), mk(0, 1, 5, '1), "R3");
    drive(mk(0, 0, 5, 8'h0F, d3), idle, "R2");
    drive(mk(0, 1, 5, '1), idle, "R2");
    drive(idle, mk(0, 1, 5, 8'hF0), "R3");
    drive(mk(0, 0, 9, 8'hF0, rdat()), mk(0, 0, 9, 8'hFF, rdat()), "R4");
    drive(mk(0, 0, 9, 8'h3C, rdat()), mk(0, 0, 9, 8'h3C, rdat()), "R4");
    drive(mk(0, 1, 9, '1), idle, "R4");
    drive(idle, idle, "R6");
    drive(mk(1, 0, 5, '1, rdat()), mk(2, 0, 5, '1, rdat()), "R1");
    drive(mk(0, 1, 5, '1), mk(2, 1, 7, '1), "R1");
    drive(mk(0, 1, 7, '1, '0, 1'b1), idle, "R5");
    drive(mk(1, 1, 0, '0), idle, "R5");
    drive(mk(0, 0, 11, '1, rdat()), idle, "R11");
    drive(mk(0, 1, 11, '1), mk(0, 0, 11, '1, rdat()), "R11");
    drive(mk(0, 1, 11, '1), idle, "R11");

    drive(mk(0, 0, MB_R, '1, rdat()), idle, "R7");
    drive(idle, mk(0, 1, MB_R, '1), "R8");
    drive(idle, mk(0, 0, MB_L, '1, rdat()), "R7");
    drive(mk(0, 1, MB_R, '1), idle, "R9");
    drive(mk(0, 0, MB_L, '1, rdat()), idle, "R9");
    drive(idle, mk(0, 1, MB_L, '1), "R9");
    drive(idle, mk(0, 0, MB_R, '1, rdat()), "R9");
    drive(mk(0, 1, MB_L, '1), idle, "R8");
    drive(mk(0, 0, MB_R, '1, rdat()), mk(0, 1, MB_R, '1), "R9");
    drive(idle, mk(0, 1, MB_R, '1), "R8");

    for (int a = 0; a < 4; a++) drive(mk(0, 0, a, '1, rdat()), idle, "R2");
    for (int n = 0; n < 300; n++) begin
      op_t o [2];
      for (int p = 0; p < 2; p++) begin
        o[p] = mk(($urandom % 6 == 0) ? 1 + int'($urandom % 2) : 0, 1'($urandom),
                  pick[$urandom % 6], LANES'($urandom), rdat(), ($urandom % 8 == 0));
      end
      drive(o[0], o[1], "R2");
    end
    repeat (6) drive(idle, idle, "R6");
    while (sb.size() != 0) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule